// File: doc/BRIEF.md
# Weighted Polling ADC Scan Sequencer

This block sequences a five-channel analog monitor that shares one 8-bit successive-approximation converter. It visits the channels in a fixed, weighted order of twelve slots. Channel 5 gets every other slot, channel 1 gets every fourth slot, and channels 2, 3 and 4 get one slot each per round. The order repeats for as long as the block runs. Each slot is a fixed number of bus-clock cycles. In each slot the block first presents the channel number to the analog multiplexer and lets it settle. It then drives a trial code to an external DAC for each bit in turn, from MSB to LSB, and reads back a single comparator bit.

The finished code goes into that channel's result register in one write. A host reading the registers therefore only ever sees completed conversions. Channels 2 and 3 each have two candidate input pins. A static select input per channel chooses the alternate pin, and the block reports that choice on a pin-select output while the channel is being sampled. The DAC, the comparator and the voltage reference are outside the block.

Top module: `adc_poll_seq`

## Requirements
- R1: Slot k after reset (k counted modulo 12) samples channel 5 when k is even, channel 1 when k is 1, 5 or 9, channel 2 when k is 3, channel 3 when k is 7 and channel 4 when k is 11. `mux_sel` carries the channel number as a binary value from 1 to 5, and every slot lasts SLOT_CYCLES (40) clock cycles.
- R2: `mux_b` is 1 only while channel 2 is sampled with `alt_sel2` = 1, or while channel 3 is sampled with `alt_sel3` = 1. For channels 1, 4 and 5 it is 0 whatever the select inputs are.
- R3: Within a slot, cycles 0 to SETTLE_CYCLES-1 (0..3) hold `trial_code` at 0. Cycles 4..11 are the eight trial steps, MSB first, so the first step shows 8'h80.
- R4: `cmp_ge` = 1 means the sampled input is at or above `trial_code`. A step keeps its trial bit when `cmp_ge` is 1 and clears it otherwise, so an input of value V (0..255) converts to code V, where 00 is the bottom of the range and FF the top.
- R5: A channel's result field changes only at the clock edge that ends cycle 12 of its slot. Mid-slot reads return the previous code.
- R6: Result field for channel c sits at `result_bus[8*(c-1)+7 : 8*(c-1)]`. A conversion writes only its own channel's field and leaves the other four unchanged.
- R7: While `rst` is high and after it falls, all result fields read 0, the round restarts at slot 0 (channel 5, cycle 0), and `trial_code` is 0.
- R8: A channel 2 or channel 3 conversion stores the value of the pin named by its select input: the B pin when the select is 1 and the A pin when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; sets slot and conversion timing |
| rst | input | 1 | Synchronous active-high reset |
| cmp_ge | input | 1 | Comparator: sampled input at or above trial_code |
| alt_sel2 | input | 1 | Channel 2 uses its B pin when 1 |
| alt_sel3 | input | 1 | Channel 3 uses its B pin when 1 |
| trial_code | output | 8 | Code to the external DAC during trial steps |
| mux_sel | output | 3 | Channel number (1..5) being sampled |
| mux_b | output | 1 | Pin B select for the sampled channel |
| result_bus | output | 40 | Five 8-bit result fields, channel 1 in the low byte |

## Verification
The bench models the analog side as a comparator that compares a per-pin value with the trial code. It gives each slot a value taken from an odd-stride walk over all 256 codes, so every code, including 00 and FF, is converted on several channels.

The A and B values of channels 2 and 3 are set to complementary codes, so a conversion from the wrong pin shows up as an inverted result. The select inputs toggle on different periods, which covers all four select combinations.

Three checks catch faults that a final-value check alone would miss:
- A probe in the middle of each slot separates a complete-then-write update from a register that builds the code in place.
- A probe at the first step checks the MSB-first order.
- Checking all five fields at every slot boundary catches writes to the wrong channel.

// File: rtl/adc_poll_pkg.sv
package adc_poll_pkg;

    localparam int NUM_SLOTS = 12;
    localparam int SLOT_W    = 4;
    localparam int CH_W      = 3;

    typedef enum logic [1:0] {
        PH_SETTLE,
        PH_STEP,
        PH_WRITE,
        PH_IDLE
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [SLOT_W-1:0] slot;
        logic              slot_end;
    } seq_state_t;

    // Weighted order: even slots -> 5; slots 1,5,9 -> 1; slots 3,7,11 -> 2,3,4
    function automatic logic [CH_W-1:0] slot_channel(input logic [SLOT_W-1:0] s);
        if (!s[0])
            return 3'd5;
        else if (!s[1])
            return 3'd1;
        else
            return {1'b0, s[3:2]} + 3'd2;
    endfunction

endpackage

// File: rtl/adc_slot_timer.sv
module adc_slot_timer
    import adc_poll_pkg::*;
#(
    parameter int SLOT_CYCLES   = 40,
    parameter int SETTLE_CYCLES = 4,
    parameter int CODE_W        = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    output seq_state_t                  st,
    output logic [$clog2(CODE_W)-1:0]   step_idx
);
    localparam int CYC_W     = $clog2(SLOT_CYCLES);
    localparam int STEP_W    = $clog2(CODE_W);
    localparam int WRITE_CYC = SETTLE_CYCLES + CODE_W;

    logic [CYC_W-1:0]  cyc_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CYC_W-1:0]  rel;
    logic              at_end;

    assign at_end = (cyc_q == CYC_W'(SLOT_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q  <= '0;
            slot_q <= '0;
        end else if (at_end) begin
            cyc_q  <= '0;
            slot_q <= (slot_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_q + 1'b1;
        end else begin
            cyc_q  <= cyc_q + 1'b1;
        end
    end

    always_comb begin
        rel         = cyc_q - CYC_W'(SETTLE_CYCLES);
        step_idx    = rel[STEP_W-1:0];
        st.slot     = slot_q;
        st.slot_end = at_end;
        if (cyc_q < CYC_W'(SETTLE_CYCLES))
            st.phase = PH_SETTLE;
        else if (cyc_q < CYC_W'(WRITE_CYC))
            st.phase = PH_STEP;
        else if (cyc_q == CYC_W'(WRITE_CYC))
            st.phase = PH_WRITE;
        else
            st.phase = PH_IDLE;
    end

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import adc_poll_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  phase_e                    phase,
    input  logic [$clog2(CODE_W)-1:0] step_idx,
    input  logic                      cmp_ge,
    output logic [CODE_W-1:0]         trial_code,
    output logic [CODE_W-1:0]         acc
);
    localparam logic [CODE_W-1:0] MSB_ONE = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] bit_mask;

    assign bit_mask   = MSB_ONE >> step_idx;
    assign trial_code = (phase == PH_STEP) ? (acc | bit_mask) : '0;

    always_ff @(posedge clk) begin
        if (rst || phase == PH_SETTLE)
            acc <= '0;
        else if (phase == PH_STEP && cmp_ge)
            acc <= acc | bit_mask;
    end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_poll_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int NUM_CH = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_ch,
    input  logic [CODE_W-1:0]        wr_data,
    output logic [NUM_CH*CODE_W-1:0] result_bus
);
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic [CODE_W-1:0] res_q;
        always_ff @(posedge clk) begin
            if (rst)
                res_q <= '0;
            else if (wr_en && wr_ch == CH_W'(k + 1))
                res_q <= wr_data;
        end
        assign result_bus[k*CODE_W +: CODE_W] = res_q;
    end

endmodule

// File: rtl/adc_poll_seq.sv
module adc_poll_seq
    import adc_poll_pkg::*;
#(
    parameter int CODE_W        = 8,
    parameter int NUM_CH        = 5,
    parameter int SLOT_CYCLES   = 40,
    parameter int SETTLE_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmp_ge,
    input  logic                     alt_sel2,
    input  logic                     alt_sel3,
    output logic [CODE_W-1:0]        trial_code,
    output logic [2:0]               mux_sel,
    output logic                     mux_b,
    output logic [NUM_CH*CODE_W-1:0] result_bus
);
    seq_state_t                st;
    logic [$clog2(CODE_W)-1:0] step_idx;
    logic [CODE_W-1:0]         acc;
    phase_e                    ph;
    logic                      slot_end;

    adc_slot_timer #(
        .SLOT_CYCLES  (SLOT_CYCLES),
        .SETTLE_CYCLES(SETTLE_CYCLES),
        .CODE_W       (CODE_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .st      (st),
        .step_idx(step_idx)
    );

    assign ph       = st.phase;
    assign slot_end = st.slot_end;
    assign mux_sel  = slot_channel(st.slot);
    assign mux_b    = (mux_sel == 3'd2 && alt_sel2) || (mux_sel == 3'd3 && alt_sel3);

    adc_sar_core #(.CODE_W(CODE_W)) u_sar (
        .clk       (clk),
        .rst       (rst),
        .phase     (ph),
        .step_idx  (step_idx),
        .cmp_ge    (cmp_ge),
        .trial_code(trial_code),
        .acc       (acc)
    );

    adc_result_bank #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ph == PH_WRITE),
        .wr_ch     (mux_sel),
        .wr_data   (acc),
        .result_bus(result_bus)
    );

endmodule

// File: rtl/adc_poll_seq_chk.sv
module adc_poll_seq_chk
    import adc_poll_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int NUM_CH = 5
) (
    input logic                     clk,
    input logic                     rst,
    input phase_e                   ph,
    input logic                     slot_end,
    input logic [2:0]               mux_sel,
    input logic                     mux_b,
    input logic [CODE_W-1:0]        trial_code,
    input logic [NUM_CH*CODE_W-1:0] result_bus
);
    logic [NUM_CH*CODE_W-1:0] prev_bus;
    logic [NUM_CH-1:0]        changed;
    logic                     prev_valid;

    always_ff @(posedge clk) begin
        prev_bus   <= result_bus;
        prev_valid <= !rst;
    end

    always_comb begin
        for (int k = 0; k < NUM_CH; k++)
            changed[k] = prev_valid &&
                         (result_bus[k*CODE_W +: CODE_W] != prev_bus[k*CODE_W +: CODE_W]);
    end

    AST_MUX_RANGE: assert property (@(posedge clk) disable iff (rst)
        mux_sel >= 3'd1 && mux_sel <= 3'd5);                                   // R1
    AST_CH5_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (slot_end && mux_sel == 3'd5) |=> mux_sel != 3'd5);                   // R1
    AST_CH5_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (slot_end && mux_sel != 3'd5) |=> mux_sel == 3'd5);                   // R1
    AST_ALT_ONLY_23: assert property (@(posedge clk) disable iff (rst)
        mux_b |-> (mux_sel == 3'd2 || mux_sel == 3'd3));                      // R2
    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_STEP && $past(ph) == PH_SETTLE) |->
            ($countones(trial_code) == 1 && trial_code[CODE_W-1]));           // R3
    AST_WRITE_SLOT_ONLY: assert property (@(posedge clk) disable iff (rst)
        (changed != '0) |-> $past(ph) == PH_WRITE);                           // R5
    AST_ONE_FIELD: assert property (@(posedge clk) disable iff (rst)
        $countones(changed) <= 1);                                            // R6

endmodule

bind adc_poll_seq adc_poll_seq_chk #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ph        (ph),
    .slot_end  (slot_end),
    .mux_sel   (mux_sel),
    .mux_b     (mux_b),
    .trial_code(trial_code),
    .result_bus(result_bus)
);

// File: tb/adc_poll_seq_bench.sv
module adc_poll_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_ge;
    logic        alt_sel2 = 1'b0;
    logic        alt_sel3 = 1'b0;
    logic [7:0]  trial_code;
    logic [2:0]  mux_sel;
    logic        mux_b;
    logic [39:0] result_bus;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // analog model: one value per pin
    logic [7:0] an1 = 0, an2a = 0, an2b = 0, an3a = 0, an3b = 0, an4 = 0, an5 = 0;
    logic [7:0] exp_res [1:5];
    logic [7:0] sel_val;

    always #10 clk = ~clk;   // 50 MHz

    adc_poll_seq u_adc_poll_seq (
        .clk(clk), .rst(rst), .cmp_ge(cmp_ge), .alt_sel2(alt_sel2), .alt_sel3(alt_sel3),
        .trial_code(trial_code), .mux_sel(mux_sel), .mux_b(mux_b), .result_bus(result_bus)
    );

    always_comb begin
        case (mux_sel)
            3'd1:    sel_val = an1;
            3'd2:    sel_val = mux_b ? an2b : an2a;
            3'd3:    sel_val = mux_b ? an3b : an3a;
            3'd4:    sel_val = an4;
            default: sel_val = an5;
        endcase
        cmp_ge = (sel_val >= trial_code);
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int field(input int ch);
        return int'(result_bus[8*(ch-1) +: 8]);
    endfunction

    initial begin
        for (int c = 1; c <= 5; c++) exp_res[c] = 8'h00;
        cycles(3);
        check("R7 reset results", int'(result_bus), 0);
        check("R7 reset trial", int'(trial_code), 0);
        rst = 1'b0;
        check("R7 restart channel", int'(mux_sel), 5);
        for (int g = 0; g < 600; g++) begin
            int s, ch, v;
            s  = g % 12;
            ch = (s % 2 == 0) ? 5 : ((s % 4 == 1) ? 1 : s / 4 + 2);
            v  = (g * 37 + 11) % 256;
            alt_sel2 = g[4];
            alt_sel3 = g[5];
            case (ch)
                1: an1 = 8'(v);
                2: begin an2a = alt_sel2 ? ~8'(v) : 8'(v); an2b = alt_sel2 ? 8'(v) : ~8'(v); end
                3: begin an3a = alt_sel3 ? ~8'(v) : 8'(v); an3b = alt_sel3 ? 8'(v) : ~8'(v); end
                4: an4 = 8'(v);
                default: an5 = 8'(v);
            endcase
            // cycle 0 of slot
            check("R1 channel order", int'(mux_sel), ch);
            check("R2 pin select", int'(mux_b),
                  ((ch == 2 && alt_sel2) || (ch == 3 && alt_sel3)) ? 1 : 0);
            check("R3 settle trial", int'(trial_code), 0);
            for (int c = 1; c <= 5; c++)
                check(c == 2 || c == 3 ? "R8 alt result" : "R4 R6 result", field(c), int'(exp_res[c]));
            cycles(4);
            check("R3 first step MSB", int'(trial_code), 8'h80);
            cycles(4);
            check("R5 no partial code", field(ch), int'(exp_res[ch]));
            cycles(32);
            exp_res[ch] = 8'(v);
        end
        check("R1 slot length final", field(5), int'(exp_res[5]));
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule